// File: doc/BRIEF.md
# CRC-32 Register-Mapped Accelerator

This peripheral computes a CRC-32 checksum over a packet that a processor first deposits, one byte per write, into a private byte buffer inside the block. The processor programs a byte count, then sets an enable bit. The engine walks the buffer one byte per clock and stores the final checksum in a result register. It then raises a done flag, which is also the interrupt line. The interrupt handler reads the result and writes a clear bit to drop the interrupt.

A sender uses the result as the trailer it places after the payload. A receiver runs the same payload through the block and compares the result with the trailer it received. The bus is a simple register port. A request with write enable low returns its read data on `rdata_o` one clock after the request edge.

Top module: `crc_accel`

## Requirements
- R1: After reset, the status word reads 0, the length register reads 0, the result register reads 0 and `irq_o` is low.
- R2: A write to byte address 0x100+i (i in 0..255) stores `wdata_i[7:0]` at buffer position i. A read from the same address returns that byte in bits 7:0, with bits 31:8 zero.
- R3: Writing the length register (offset 0x08) stores the byte count and reads it back. A written value above 256 is stored as 256.
- R4: Writing bit 0 of the control register (offset 0x00) while the engine is idle starts a run over buffer bytes 0..L-1, where L is the length. The engine takes one byte per clock, so for L>0 `irq_o` rises exactly L clocks after the clock edge that accepted the enable write.
- R5: The result register (offset 0x0C) holds the CRC-32 of the covered bytes, using polynomial 0x04C11DB7, initial value 0xFFFFFFFF, bit-reflected input and output, and final XOR 0xFFFFFFFF. The value is valid from the same edge at which done rises. For the bytes "123456789" the result is 0xCBF43926.
- R6: `irq_o` equals the done flag. It stays high until a control write with bit 1 set, which drops it on the next edge.
- R7: If a clear write is accepted in the same clock as a run completes, the completion wins and `irq_o` is high afterwards.
- R8: While a run is busy, writes to the enable bit, the length register and the buffer have no effect. The running checksum, the length readback and the buffer contents all stay unchanged.
- R9: A run with length 0 sets done at the edge that accepts the enable write, and the result is 0x00000000.
- R10: The status register (offset 0x04) reports done in bit 0 and busy in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address: registers below 0x100, buffer at 0x100 and above |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read request |
| irq_o | output | 1 | Completion interrupt, high while done is set |

## Verification
Two events can fall in the same clock: the engine finishing its last byte and the processor writing the interrupt clear bit. The bench provokes this by counting clocks from the accepted enable write so that the clear write lands on exactly the L-th edge. It then expects `irq_o` to remain high, and a second clear must drop it. A related overlap is covered the same way: an enable write arriving while a run is busy is shown to change neither the checksum nor the completion.

// File: rtl/crc_accel_pkg.sv
package crc_accel_pkg;

  localparam logic [31:0] CRC_POLY   = 32'h04C11DB7;
  localparam logic [31:0] CRC_INIT   = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_XOROUT = 32'hFFFFFFFF;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_STAT = 8'h04;
  localparam logic [7:0] OFF_LEN  = 8'h08;
  localparam logic [7:0] OFF_RES  = 8'h0C;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_BUSY_BIT = 1;

  function automatic logic [31:0] rev32(logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  localparam logic [31:0] CRC_POLY_REV = rev32(CRC_POLY);

  // reflected, LSB-first byte update
  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'b0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
    return r;
  endfunction

endpackage

// File: rtl/crc_byte_buf.sv
module crc_byte_buf #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] eng_addr_i,
  output logic [7:0]    eng_data_o,
  input  logic [AW-1:0] bus_addr_i,
  output logic [7:0]    bus_data_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign eng_data_o = mem_q[eng_addr_i];
  assign bus_data_o = mem_q[bus_addr_i];
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_accel_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] idx_o,
  input  logic [7:0]    byte_i,
  output logic          busy_o,
  output logic          fin_o,
  output logic [31:0]   result_o
);
  logic          busy_q;
  logic [LW-1:0] cnt_q;
  logic [31:0]   crc_q, crc_nxt, result_q;
  logic          last;

  assign crc_nxt = crc_step(crc_q, byte_i);
  assign last    = busy_q && (cnt_q == len_i - LW'(1));
  assign fin_o   = (start_i && len_i == '0) || last;
  assign idx_o   = cnt_q[AW-1:0];
  assign busy_o  = busy_q;
  assign result_o = result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      crc_q    <= CRC_INIT;
      result_q <= '0;
    end else if (start_i) begin
      crc_q  <= CRC_INIT;
      cnt_q  <= '0;
      busy_q <= (len_i != '0);
      if (len_i == '0) result_q <= CRC_INIT ^ CRC_XOROUT;
    end else if (busy_q) begin
      crc_q <= crc_nxt;
      cnt_q <= cnt_q + LW'(1);
      if (last) begin
        busy_q   <= 1'b0;
        result_q <= rev32(rev32(crc_nxt)) ^ CRC_XOROUT;
      end
    end
  end
endmodule

// File: rtl/crc_reg_if.sv
module crc_reg_if
  import crc_accel_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int ADDR_W = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic [31:0]       result_i,
  output logic              start_o,
  output logic [LW-1:0]     len_o,
  output logic              buf_we_o,
  output logic [AW-1:0]     buf_addr_o,
  input  logic [7:0]        buf_rbyte_i,
  output logic              done_o
);
  logic          is_buf, wr, rd, ctrl_wr, clr;
  logic [7:0]    off;
  logic [LW-1:0] len_q;
  logic          done_q;
  logic [31:0]   rdata_q, stat;

  assign is_buf  = addr_i[AW];
  assign off     = 8'(addr_i[AW-1:0]);
  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign ctrl_wr = wr && !is_buf && off == OFF_CTRL;
  assign clr     = ctrl_wr && wdata_i[CTRL_CLR_BIT];

  assign start_o    = ctrl_wr && wdata_i[CTRL_EN_BIT] && !busy_i;
  assign buf_we_o   = wr && is_buf && !busy_i;
  assign buf_addr_o = addr_i[AW-1:0];
  assign len_o      = len_q;
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;

  always_comb begin
    stat = '0;
    stat[STAT_DONE_BIT] = done_q;
    stat[STAT_BUSY_BIT] = busy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (wr && !is_buf && off == OFF_LEN && !busy_i)
        len_q <= (wdata_i > 32'(DEPTH)) ? LW'(DEPTH) : wdata_i[LW-1:0];
      // completion dominates a clear in the same cycle
      if (fin_i)    done_q <= 1'b1;
      else if (clr) done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd) begin
      if (is_buf) rdata_q <= {24'b0, buf_rbyte_i};
      else begin
        unique case (off)
          OFF_STAT: rdata_q <= stat;
          OFF_LEN:  rdata_q <= 32'(len_q);
          OFF_RES:  rdata_q <= result_i;
          default:  rdata_q <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/crc_accel.sv
module crc_accel #(
  parameter int BUF_DEPTH = 256,
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int LW = $clog2(BUF_DEPTH + 1),
  localparam int ADDR_W = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  logic          start, busy, fin, buf_we, done;
  logic [LW-1:0] len;
  logic [AW-1:0] buf_addr, rd_idx;
  logic [7:0]    eng_byte, bus_byte;
  logic [31:0]   result;

  crc_reg_if #(.DEPTH(BUF_DEPTH)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .fin_i(fin), .result_i(result), .start_o(start),
    .len_o(len), .buf_we_o(buf_we), .buf_addr_o(buf_addr),
    .buf_rbyte_i(bus_byte), .done_o(done)
  );

  crc_byte_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk_i, .we_i(buf_we), .waddr_i(buf_addr), .wdata_i(wdata_i[7:0]),
    .eng_addr_i(rd_idx), .eng_data_o(eng_byte),
    .bus_addr_i(buf_addr), .bus_data_o(bus_byte)
  );

  crc_engine #(.DEPTH(BUF_DEPTH)) u_eng (
    .clk_i, .rst_ni, .start_i(start), .len_i(len), .idx_o(rd_idx),
    .byte_i(eng_byte), .busy_o(busy), .fin_o(fin), .result_o(result)
  );

  assign irq_o = done;
endmodule

// File: rtl/crc_accel_chk.sv
module crc_accel_chk
  import crc_accel_pkg::*;
#(
  parameter int BUF_DEPTH = 256,
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int LW = $clog2(BUF_DEPTH + 1),
  localparam int ADDR_W = AW + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              irq_o,
  input logic              busy_i,
  input logic              fin_i,
  input logic [LW-1:0]     len_i,
  input logic [AW-1:0]     idx_i
);
  logic clr_wr;
  assign clr_wr = req_i && we_i && !addr_i[AW] && 8'(addr_i[AW-1:0]) == OFF_CTRL
                  && wdata_i[CTRL_CLR_BIT];

  p_len_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(len_i) <= 32'(BUF_DEPTH));

  p_idx_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> 32'(idx_i) < 32'(len_i));

  p_done_after_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !busy_i);

  p_clear_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && !fin_i |=> !irq_o);

  p_irq_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_wr |=> irq_o);

  p_fin_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> irq_o);

  p_len_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(len_i));
endmodule

bind crc_accel crc_accel_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .busy_i(busy), .fin_i(fin), .len_i(len),
  .idx_i(rd_idx)
);

// File: tb/tb_crc_accel.sv
module tb_crc_accel;
  localparam int DEPTH = 256;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0] ref_mem [DEPTH];

  always #2 clk = ~clk;

  crc_accel #(.BUF_DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); #1;
    req = 1'b0;
    d = rdata;
  endtask

  task automatic put_byte(int i, logic [7:0] b);
    bus_write(AW'(9'h100 + i), {24'b0, b});
    ref_mem[i] = b;
  endtask

  function automatic logic [31:0] ref_crc(int n);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [7:0]  b;
    logic [31:0] r;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) b[k] = ref_mem[i][7-k];
      c = c ^ {b, 24'b0};
      for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
    end
    for (int k = 0; k < 32; k++) r[k] = c[31-k];
    return r ^ 32'hFFFFFFFF;
  endfunction

  // start with length n already programmed; check irq timing and result
  task automatic run_job(string tag, int n);
    logic [31:0] d;
    bus_write(9'h000, 32'h1);
    if (n == 0) chk({tag, " R9 irq after start"}, 32'(irq), 32'd1);
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); #1;
      if (k == n - 1) chk({tag, " R4 irq before last"}, 32'(irq), 32'd0);
      if (k == n)     chk({tag, " R4 irq at L"}, 32'(irq), 32'd1);
    end
    bus_read(9'h00C, d);
    chk({tag, " R5 result"}, d, ref_crc(n));
    bus_write(9'h000, 32'h2);
    chk({tag, " R6 cleared"}, 32'(irq), 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 32'd0);
    bus_read(9'h004, d); chk("R1 R10 status", d, 32'd0);
    bus_read(9'h008, d); chk("R1 length", d, 32'd0);
    bus_read(9'h00C, d); chk("R1 result", d, 32'd0);
  endtask

  task automatic t_buf_rw();
    logic [31:0] d;
    put_byte(0, 8'h5A); put_byte(255, 8'hC3);
    bus_write(9'h101, 32'hDEAD_BE77); ref_mem[1] = 8'h77;
    bus_read(9'h100, d); chk("R2 byte0", d, 32'h5A);
    bus_read(9'h1FF, d); chk("R2 byte255", d, 32'hC3);
    bus_read(9'h101, d); chk("R2 low byte only", d, 32'h77);
  endtask

  task automatic t_len();
    logic [31:0] d;
    bus_write(9'h008, 32'd300); bus_read(9'h008, d); chk("R3 clamp", d, 32'd256);
    bus_write(9'h008, 32'd7);   bus_read(9'h008, d); chk("R3 plain", d, 32'd7);
  endtask

  task automatic t_known();
    logic [31:0] d;
    string s = "123456789";
    for (int i = 0; i < 9; i++) put_byte(i, s[i]);
    bus_write(9'h008, 32'd9);
    bus_write(9'h000, 32'h1);
    for (int k = 1; k <= 9; k++) begin
      @(posedge clk); #1;
      if (k == 8) chk("R4 no irq at L-1", 32'(irq), 32'd0);
    end
    chk("R4 irq at L", 32'(irq), 32'd1);
    bus_read(9'h00C, d); chk("R5 check value", d, 32'hCBF43926);
    bus_read(9'h004, d); chk("R10 done only", d, 32'h1);
    repeat (5) @(posedge clk); #1;
    chk("R6 irq held", 32'(irq), 32'd1);
    bus_write(9'h000, 32'h2);
    chk("R6 clear", 32'(irq), 32'd0);
    bus_read(9'h004, d); chk("R6 R10 status cleared", d, 32'h0);
  endtask

  task automatic t_patterns();
    put_byte(0, 8'h00);
    bus_write(9'h008, 32'd1); run_job("single", 1);
    for (int i = 0; i < 33; i++) put_byte(i, 8'hFF);
    bus_write(9'h008, 32'd33); run_job("ones", 33);
    for (int i = 0; i < DEPTH; i++) put_byte(i, 8'(i * 7 + 3));
    bus_write(9'h008, 32'd256); run_job("full", 256);
  endtask

  task automatic t_zero();
    bus_write(9'h008, 32'd0);
    run_job("R9 zero", 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d, exp;
    for (int i = 0; i < 64; i++) put_byte(i, 8'(i ^ 8'h96));
    bus_write(9'h008, 32'd64);
    exp = ref_crc(64);
    bus_write(9'h000, 32'h1);
    bus_read(9'h004, d); chk("R10 busy bit", d & 32'h2, 32'h2);
    bus_write(9'h008, 32'd5);
    bus_write(9'h100, 32'hAA);
    bus_write(9'h000, 32'h1);
    repeat (70) @(posedge clk); #1;
    bus_read(9'h00C, d); chk("R8 result unchanged", d, exp);
    bus_read(9'h008, d); chk("R8 length kept", d, 32'd64);
    bus_read(9'h100, d); chk("R8 buffer kept", d, 32'(ref_mem[0]));
    bus_write(9'h000, 32'h2);
  endtask

  task automatic t_collide();
    for (int i = 0; i < 5; i++) put_byte(i, 8'(8'h10 + i));
    bus_write(9'h008, 32'd5);
    bus_write(9'h000, 32'h1);
    repeat (4) @(posedge clk);
    bus_write(9'h000, 32'h2);  // accepted on the completion edge
    chk("R7 completion wins", 32'(irq), 32'd1);
    bus_write(9'h000, 32'h2);
    chk("R7 later clear", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_buf_rw();
    t_len();
    t_known();
    t_patterns();
    t_zero();
    t_busy_ignore();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule